// File: doc/BRIEF.md
# Four-Channel Shadowed-Update PWM Controller

This block drives four pulse-width outputs from one clock. Each channel scales the input clock down by a power of two and runs a period counter. It compares that counter with a threshold to choose the output level. Software reaches the block over a small synchronous bus, and every access takes one cycle. Each channel has two live registers, one for the period and one for the inactive-cycle threshold. Each live register has a staging copy. A value written to a staging copy moves into the live register only when a period wraps, so a running waveform never shows a partial period. Global registers start and stop channels, report which channels are running, and collect the end-of-period events. Reading the event register clears it.

The threshold register holds the number of inactive cycles at the start of each period. The output is active for the remaining `period - threshold` counts. A stop request does not cut the current period short: the channel finishes it and then goes idle. Read data appears on `rdata_o` in the cycle after the request.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low, and the running status, the event status and every channel register read as 0.
- R2: A write to global address 0x004 starts every channel whose bit is set in the write data, where bit n is channel n. Global 0x00C reads the running status with the same bit mapping. Channel n's registers sit at 0x200 + n*0x20, at these offsets: mode 0x00, live threshold 0x04, staged threshold 0x08, live period 0x0C, staged period 0x10. Mode bits [3:0] hold the scaling exponent and bit 9 holds the polarity, and the mode register reads back as written.
- R3: The period counter of a running channel advances once every 2^p clocks, where p is the mode exponent. An exponent above 10 behaves as 10.
- R4: With polarity 0, a running output is low while the counter is below the live threshold and high from there to the end of the period. The counter runs from 0 to period-1.
- R5: Polarity 1 inverts the output. A stopped channel holds its inactive level, which is low for polarity 0 and high for polarity 1.
- R6: A value written to a staged register reaches the matching live register only at the next period wrap. Until then the live register reads its old value.
- R7: Writes to the live period and threshold registers take effect only while the channel is stopped. While the channel runs they are ignored.
- R8: Each period wrap of a running channel sets bit n of the event register at global 0x01C. A read returns the register's contents and clears it.
- R9: An event that arrives in the same cycle as a read of the event register stays set after that read.
- R10: A write of bit n to global 0x008 stops channel n at the end of its current period. Its running bit stays 1 and its output keeps toggling until that point.
- R11: Starting a channel, even one that is already running, resets its counter and its clock scaler to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pwm_o | output | 4 | Channel outputs, bit n is channel n |

## Verification
The hardest case to reach is a read of the event register that lands in the same clock edge as a period wrap. The bench restarts channel 0 with a known period and clears the event register straight after the restart. It then counts clock edges from the restart, so the second read can be placed exactly on the wrap edge. A further read confirms that the event survived. The delayed stop is reached the same way: the stop request goes in mid-period, and the bench samples the running bit and the output on either side of the wrap edge.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam logic [11:0] G_START = 12'h004;
  localparam logic [11:0] G_STOP  = 12'h008;
  localparam logic [11:0] G_RUN   = 12'h00C;
  localparam logic [11:0] G_EVT   = 12'h01C;
  localparam logic [4:0] O_MODE   = 5'h00;
  localparam logic [4:0] O_THR    = 5'h04;
  localparam logic [4:0] O_THR_S  = 5'h08;
  localparam logic [4:0] O_PER    = 5'h0C;
  localparam logic [4:0] O_PER_S  = 5'h10;
  localparam int unsigned POL_BIT = 9;

  typedef struct packed {
    logic mode;
    logic thr;
    logic thr_s;
    logic per;
    logic per_s;
  } ch_wr_t;
endpackage

// File: rtl/pwm_scaler.sv
module pwm_scaler #(
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned MAX_PRE = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (MAX_PRE > 0) ? MAX_PRE : 1;
  localparam logic [PRE_W-1:0] SEL_MAX = PRE_W'(MAX_PRE);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] sel_eff;
  logic [DIV_W:0]   mask_w;
  logic [DIV_W-1:0] mask;

  // exponents above the limit saturate
  assign sel_eff = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
  assign mask_w  = ((DIV_W+1)'(1) << sel_eff) - (DIV_W+1)'(1);
  assign mask    = mask_w[DIV_W-1:0];
  assign tick_o  = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned MAX_PRE = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_wr_t           wr_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             pol_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             run_o,
  output logic             evt_o,
  output logic             pwm_o,
  output logic [PRE_W-1:0] pre_o,
  output logic             pol_o,
  output logic [CNT_W-1:0] thr_o,
  output logic [CNT_W-1:0] thr_s_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_s_o
);
  logic [PRE_W-1:0] pre_q;
  logic             pol_q, run_q, stop_q;
  logic [CNT_W-1:0] thr_q, thr_s_q, per_q, per_s_q, cnt_q;
  logic             thr_pend_q, per_pend_q;
  logic             tick, wrap;

  pwm_scaler #(.PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_scaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (start_i),
    .sel_i     (pre_q),
    .tick_o    (tick)
  );

  // last count of the period; a zero period wraps on every tick
  assign wrap = tick && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      pol_q      <= 1'b0;
      run_q      <= 1'b0;
      stop_q     <= 1'b0;
      thr_q      <= '0;
      thr_s_q    <= '0;
      per_q      <= '0;
      per_s_q    <= '0;
      cnt_q      <= '0;
      thr_pend_q <= 1'b0;
      per_pend_q <= 1'b0;
    end else begin
      if (wr_i.mode) begin
        pre_q <= pre_i;
        pol_q <= pol_i;
      end
      if (start_i) begin
        run_q  <= 1'b1;
        stop_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        if (stop_i && run_q) stop_q <= 1'b1;
        if (wrap) begin
          cnt_q <= '0;
          if (stop_q || stop_i) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
          end
        end else if (tick) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (wrap && thr_pend_q) begin
        thr_q      <= thr_s_q;
        thr_pend_q <= 1'b0;
      end
      if (wrap && per_pend_q) begin
        per_q      <= per_s_q;
        per_pend_q <= 1'b0;
      end
      if (wr_i.thr && !run_q) thr_q <= val_i;
      if (wr_i.per && !run_q) per_q <= val_i;
      if (wr_i.thr_s) begin
        thr_s_q    <= val_i;
        thr_pend_q <= 1'b1;
      end
      if (wr_i.per_s) begin
        per_s_q    <= val_i;
        per_pend_q <= 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign evt_o   = wrap;
  assign pwm_o   = run_q ? ((cnt_q >= thr_q) ^ pol_q) : pol_q;
  assign pre_o   = pre_q;
  assign pol_o   = pol_q;
  assign thr_o   = thr_q;
  assign thr_s_o = thr_s_q;
  assign per_o   = per_q;
  assign per_s_o = per_s_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned MAX_PRE = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              in_ch;
  logic [CH_W-1:0]   ch_sel;
  logic [4:0]        ofs;
  logic              wr, rd, rd_evt;
  logic [NUM_CH-1:0] start_v, stop_v, run_v, evt_v, pol_v, isr_q;
  logic [31:0]       rd_mux, rdata_q;

  logic [PRE_W-1:0]  pre_a   [NUM_CH];
  logic [CNT_W-1:0]  thr_a   [NUM_CH];
  logic [CNT_W-1:0]  thr_s_a [NUM_CH];
  logic [CNT_W-1:0]  per_a   [NUM_CH];
  logic [CNT_W-1:0]  per_s_a [NUM_CH];

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign in_ch   = (addr_i[11:9] == 3'b001) && (int'(addr_i[8:5]) < NUM_CH);
  assign ch_sel  = addr_i[5 +: CH_W];
  assign ofs     = addr_i[4:0];
  assign start_v = (wr && addr_i == G_START) ? wdata_i[NUM_CH-1:0] : '0;
  assign stop_v  = (wr && addr_i == G_STOP)  ? wdata_i[NUM_CH-1:0] : '0;
  assign rd_evt  = rd && (addr_i == G_EVT);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_wr_t wr_c;
    logic   hit;
    assign hit        = wr && in_ch && (ch_sel == CH_W'(c));
    assign wr_c.mode  = hit && (ofs == O_MODE);
    assign wr_c.thr   = hit && (ofs == O_THR);
    assign wr_c.thr_s = hit && (ofs == O_THR_S);
    assign wr_c.per   = hit && (ofs == O_PER);
    assign wr_c.per_s = hit && (ofs == O_PER_S);

    pwm_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_c),
      .val_i   (wdata_i[CNT_W-1:0]),
      .pre_i   (wdata_i[PRE_W-1:0]),
      .pol_i   (wdata_i[POL_BIT]),
      .start_i (start_v[c]),
      .stop_i  (stop_v[c]),
      .run_o   (run_v[c]),
      .evt_o   (evt_v[c]),
      .pwm_o   (pwm_o[c]),
      .pre_o   (pre_a[c]),
      .pol_o   (pol_v[c]),
      .thr_o   (thr_a[c]),
      .thr_s_o (thr_s_a[c]),
      .per_o   (per_a[c]),
      .per_s_o (per_s_a[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_ch) begin
      unique case (ofs)
        O_MODE: begin
          rd_mux[PRE_W-1:0] = pre_a[ch_sel];
          rd_mux[POL_BIT]   = pol_v[ch_sel];
        end
        O_THR:   rd_mux[CNT_W-1:0] = thr_a[ch_sel];
        O_THR_S: rd_mux[CNT_W-1:0] = thr_s_a[ch_sel];
        O_PER:   rd_mux[CNT_W-1:0] = per_a[ch_sel];
        O_PER_S: rd_mux[CNT_W-1:0] = per_s_a[ch_sel];
        default: rd_mux = '0;
      endcase
    end else if (addr_i == G_RUN) begin
      rd_mux[NUM_CH-1:0] = run_v;
    end else if (addr_i == G_EVT) begin
      rd_mux[NUM_CH-1:0] = isr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q   <= '0;
      rdata_q <= '0;
    end else begin
      // events of the read cycle survive the clear
      isr_q <= rd_evt ? evt_v : (isr_q | evt_v);
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] pwm_i,
  input logic [NUM_CH-1:0] run_i,
  input logic [NUM_CH-1:0] evt_i,
  input logic [NUM_CH-1:0] pol_i,
  input logic [NUM_CH-1:0] isr_i,
  input logic              rd_evt_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    p_idle_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[c] |-> (pwm_i[c] == pol_i[c]));
    p_evt_only_running_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[c] |-> run_i[c]);
    p_evt_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[c] |=> isr_i[c]);
    p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_evt_i && !evt_i[c]) |=> !isr_i[c]);
    p_stop_at_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && !evt_i[c]) |=> run_i[c]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_o),
  .run_i    (run_v),
  .evt_i    (evt_v),
  .pol_i    (pol_v),
  .isr_i    (isr_q),
  .rd_evt_i (rd_evt)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  localparam logic [11:0] A_START = 12'h004, A_STOP = 12'h008,
                          A_RUN = 12'h00C, A_EVT = 12'h01C;

  function automatic logic [11:0] ca(int ch, logic [4:0] o);
    return 12'h200 + 12'(ch * 32) + 12'(o);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pwm(int ch, bit exp, string tag);
    check(tag, 32'(pwm_o[ch]), 32'(exp));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, logic [31:0] msk, string tag);
    exp_q.push_back(exp); msk_q.push_back(msk); tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // monitor: compare read data in the cycle after the request
  initial forever begin
    @(posedge clk);
    rd_seen = req_i && !we_i;
    @(negedge clk);
    if (rd_seen) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
      check(t, rdata_o & m, e & m);
    end
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    check("R1 pwm", 32'(pwm_o), 32'h0);
    rd(A_RUN, 0, 32'hFFFF_FFFF, "R1 run");
    rd(A_EVT, 0, 32'hFFFF_FFFF, "R1 evt");
    rd(ca(0, 5'h0C), 0, 32'hFFFF_FFFF, "R1 period");

    // R4 waveform on channel 0: period 8, threshold 3
    wr(ca(0, 5'h00), 0);
    wr(ca(0, 5'h0C), 8);
    wr(ca(0, 5'h04), 3);
    rd(ca(0, 5'h0C), 8, 32'hFFFF_FFFF, "R7 stopped write");
    wr(A_START, 1);
    for (int k = 0; k < 16; k++) begin
      chk_pwm(0, (k % 8) >= 3, "R4");
      step(1);
    end
    rd(A_RUN, 1, 1, "R2 run bit");

    // R5 polarity on channel 2
    wr(ca(2, 5'h00), 32'h200);
    chk_pwm(2, 1'b1, "R5 idle high");
    rd(ca(2, 5'h00), 32'h200, 32'hFFFF_FFFF, "R2 mode readback");
    wr(ca(2, 5'h0C), 4);
    wr(ca(2, 5'h04), 1);
    wr(A_START, 4);
    for (int k = 0; k < 8; k++) begin
      chk_pwm(2, !((k % 4) >= 1), "R5 inverted");
      step(1);
    end
    wr(A_STOP, 4);
    step(8);
    chk_pwm(2, 1'b1, "R5 stopped high");
    rd(A_RUN, 0, 4, "R10 ch2 stopped");

    // R6 / R7 staged update on channel 1
    wr(ca(1, 5'h0C), 10);
    wr(ca(1, 5'h04), 4);
    wr(A_START, 2);
    wr(ca(1, 5'h08), 6);
    wr(ca(1, 5'h10), 12);
    rd(ca(1, 5'h04), 4, 32'hFFFF_FFFF, "R6 thr held");
    rd(ca(1, 5'h0C), 10, 32'hFFFF_FFFF, "R6 per held");
    rd(ca(1, 5'h08), 6, 32'hFFFF_FFFF, "R2 staged readback");
    step(6);
    rd(ca(1, 5'h04), 6, 32'hFFFF_FFFF, "R6 thr moved");
    rd(ca(1, 5'h0C), 12, 32'hFFFF_FFFF, "R6 per moved");
    wr(ca(1, 5'h04), 9);
    rd(ca(1, 5'h04), 6, 32'hFFFF_FFFF, "R7 running write ignored");
    wr(A_STOP, 2);
    step(30);

    // R3 scaling on channel 3
    wr(ca(3, 5'h00), 2);
    wr(ca(3, 5'h0C), 4);
    wr(ca(3, 5'h04), 2);
    wr(A_START, 8);
    for (int k = 0; k < 32; k++) begin
      chk_pwm(3, ((k / 4) % 4) >= 2, "R3 p2");
      step(1);
    end
    wr(A_STOP, 8);
    step(20);
    wr(ca(3, 5'h00), 15);
    wr(ca(3, 5'h0C), 2);
    wr(ca(3, 5'h04), 1);
    wr(A_START, 8);
    step(1023);
    chk_pwm(3, 1'b0, "R3 clamp before");
    step(1);
    chk_pwm(3, 1'b1, "R3 clamp edge");
    wr(A_STOP, 8);
    step(1100);

    // R11 restart, R9 collision, R10 delayed stop on channel 0
    wr(A_START, 1);
    rd(A_EVT, 0, 0, "R8 flush");
    chk_pwm(0, 1'b0, "R11 restart low");
    step(2);
    chk_pwm(0, 1'b1, "R11 restart high");
    step(4);
    rd(A_EVT, 0, 1, "R9 read on wrap edge");
    rd(A_EVT, 1, 1, "R9 event kept");
    wr(A_STOP, 1);
    rd(A_RUN, 1, 1, "R10 still running");
    chk_pwm(0, 1'b1, "R10 still toggling");
    step(4);
    chk_pwm(0, 1'b1, "R10 last count");
    step(1);
    chk_pwm(0, 1'b0, "R10 stopped idle");
    rd(A_RUN, 0, 1, "R10 run cleared");
    rd(A_EVT, 1, 1, "R8 final event");
    rd(A_EVT, 0, 32'hF, "R8 cleared by read");
    step(3);
    check("queue drained", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule